// File: doc/BRIEF.md
# Bitmask Dictionary Code Decoder

This block rebuilds a stream of 8-bit words from a compact serial code. Code bits arrive one per handshake beat, first bit first. They collect in an internal buffer until a whole code is present. That code is then decoded into one output word, or into a run of repeats of the last word. A code can take one of four forms:

- a raw word, carried in full;
- a direct reference to one of two dictionary entries;
- a dictionary entry with a 2-bit flip pattern applied at an even bit pair;
- a repeat command that re-emits the previous word.

The two dictionary entries are written through a small configuration port before decoding starts. They may be rewritten later, and codes decoded after the write see the new value.

The flip pattern is placed at its bit pair while the dictionary entry is selected, and a single XOR merges the two. A bitmask code therefore takes no longer to decode than a direct code. A flip pattern of zero would change nothing, so that value is reused as the repeat command. The repeat count is taken from the bits that would otherwise give the position and the index.

Top module: `bitmask_decoder`

## Requirements
- R1: A code whose first bit is 1 is 9 bits long. The 8 bits after the flag form the output word, the earliest received bit becoming bit 7.
- R2: A code starting 0,1 is 3 bits long. Its third bit selects a dictionary entry, and that entry is the output word.
- R3: A code starting 0,0 is 7 bits long, in the order: position (2 bits, first bit most significant), pattern (2 bits), index (1 bit). If the pattern is nonzero, the output is the indexed entry XOR the pattern placed at a bit pair. Position 0 selects bits 7:6, position 1 bits 5:4, position 2 bits 3:2 and position 3 bits 1:0.
- R4: A 7-bit code with pattern 00 is a repeat. The count is {position, index}, a 3-bit value, and the most recent output word is emitted that many more times, one per accepted output beat. A count of 0 emits nothing.
- R5: A repeat code decoded before any word has been output raises errPulse for exactly one cycle and produces no output.
- R6: outValid rises one clock after the clock edge that accepts a code's last bit. The delay is the same for raw, direct and bitmask codes. inReady is low during that cycle.
- R7: While outValid is high and outReady is low, outWord and outValid hold and inReady stays low. No input bit is taken and no word is dropped or emitted twice.
- R8: After reset, outValid and errPulse are low and inReady is high.
- R9: A write with cfgWe high stores cfgWord into entry cfgIdx. Codes decoded after the write use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Dictionary write strobe |
| cfgIdx | input | 1 | Dictionary entry to write |
| cfgWord | input | 8 | Dictionary value to write |
| inBit | input | 1 | Serial code bit |
| inValid | input | 1 | inBit is valid |
| inReady | output | 1 | Block takes inBit on this edge when inValid is high |
| outWord | output | 8 | Decoded word |
| outValid | output | 1 | outWord is valid |
| outReady | input | 1 | Consumer accepts outWord |
| errPulse | output | 1 | One-cycle flag for a repeat with no previous word |

## Verification
Every decoded word is due exactly one clock after the edge that takes the last code bit, and the error pulse is due on that same clock. The bench drives bits on falling edges. After the last bit it checks at the next falling edge that nothing is yet valid, and at the one after that it checks the word or the pulse. Repeat runs are counted beat by beat with outReady held high, then idle is confirmed. Stalls are checked on each falling edge while outReady is low.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // append inBit to the code buffer
    logic clearBuf;  // code consumed, empty the buffer
    logic loadWord;  // capture decoded word into the output register
  } ctlStrobes_t;
endpackage

// File: rtl/bmd_datapath.sv
module bmd_datapath
  import bmd_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DICT_N = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic                      inBit,
  input  logic                      cfgWe,
  input  logic [$clog2(DICT_N)-1:0] cfgIdx,
  input  logic [WORD_W-1:0]         cfgWord,
  output logic                      codeDone,
  output logic                      isRepeat,
  output logic [$clog2(WORD_W/2)+$clog2(DICT_N)-1:0] runCount,
  output logic [WORD_W-1:0]         outWord
);
  localparam int IDX_W    = $clog2(DICT_N);
  localparam int NPOS     = WORD_W / 2;
  localparam int POS_W    = $clog2(NPOS);
  localparam int RAW_LEN  = 1 + WORD_W;
  localparam int DIR_LEN  = 2 + IDX_W;
  localparam int MASK_LEN = 2 + POS_W + 2 + IDX_W;
  localparam int BUF_W    = RAW_LEN;
  localparam int CNT_W    = $clog2(BUF_W + 1);

  logic [BUF_W-1:0]  bitBuf;     // bitBuf[k] = k-th received bit
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] dict [DICT_N];

  logic              leadBit, kindBit;
  logic [WORD_W-1:0] rawWord, maskVec, entry, decoded;
  logic [IDX_W-1:0]  dirIdx, maskIdx, selIdx;
  logic [POS_W-1:0]  maskPos;
  logic [1:0]        maskPat;

  // code buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      bitBuf <= '0;
    end else if (ctl.clearBuf) begin
      bitCnt <= '0;
    end else if (ctl.shiftIn && bitCnt < CNT_W'(BUF_W)) begin
      bitBuf[bitCnt] <= inBit;
      bitCnt         <= bitCnt + 1'b1;
    end
  end

  // dictionary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DICT_N; i++) dict[i] <= '0;
    end else if (cfgWe) begin
      dict[cfgIdx] <= cfgWord;
    end
  end

  // field extraction
  always_comb begin
    leadBit = bitBuf[0];
    kindBit = bitBuf[1];
    for (int i = 0; i < WORD_W; i++) rawWord[WORD_W-1-i] = bitBuf[1+i];
    for (int i = 0; i < IDX_W; i++)  dirIdx[IDX_W-1-i]   = bitBuf[2+i];
    for (int i = 0; i < POS_W; i++)  maskPos[POS_W-1-i]  = bitBuf[2+i];
    for (int i = 0; i < 2; i++)      maskPat[1-i]        = bitBuf[2+POS_W+i];
    for (int i = 0; i < IDX_W; i++)  maskIdx[IDX_W-1-i]  = bitBuf[4+POS_W+i];
  end

  // full-width mask, built beside the dictionary read
  for (genvar p = 0; p < NPOS; p++) begin : g_slot
    assign maskVec[WORD_W-1-2*p -: 2] = (maskPos == POS_W'(p)) ? maskPat : 2'b00;
  end

  assign selIdx  = kindBit ? dirIdx : maskIdx;
  assign entry   = dict[selIdx];
  assign decoded = leadBit ? rawWord : (entry ^ (kindBit ? '0 : maskVec));

  always_comb begin
    codeDone = 1'b0;
    if (bitCnt != '0) begin
      if (leadBit)             codeDone = (bitCnt == CNT_W'(RAW_LEN));
      else if (bitCnt >= CNT_W'(2))
        codeDone = kindBit ? (bitCnt == CNT_W'(DIR_LEN)) : (bitCnt == CNT_W'(MASK_LEN));
    end
  end

  assign isRepeat = !leadBit && !kindBit && (maskPat == 2'b00);
  assign runCount = {maskPos, maskIdx};

  always_ff @(posedge clk) begin
    if (!rstN)             outWord <= '0;
    else if (ctl.loadWord) outWord <= decoded;
  end

  // R6: a complete code is consumed on the next edge
  a_r6_code_consumed: assert property (@(posedge clk) disable iff (!rstN)
    codeDone |=> (bitCnt == '0));
  // R6: buffer never holds more than one maximal code
  a_r6_buf_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BUF_W));
endmodule

// File: rtl/bmd_control.sv
module bmd_control
  import bmd_pkg::*;
#(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             codeDone,
  input  logic             isRepeat,
  input  logic [RUN_W-1:0] runCount,
  output ctlStrobes_t      ctl,
  output logic             inReady,
  output logic             outValid,
  output logic             errPulse
);
  logic [RUN_W-1:0] runLeft;
  logic             haveLast;
  logic             decodeNow;

  assign decodeNow = codeDone && !outValid;
  assign inReady   = !outValid && !codeDone;

  always_comb begin
    ctl          = '0;
    ctl.shiftIn  = inValid && inReady;
    ctl.clearBuf = decodeNow;
    ctl.loadWord = decodeNow && !isRepeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      runLeft  <= '0;
      haveLast <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= 1'b0;
      if (outValid && outReady) begin
        if (runLeft != '0) runLeft  <= runLeft - 1'b1;
        else               outValid <= 1'b0;
      end
      if (decodeNow) begin
        if (!isRepeat) begin
          outValid <= 1'b1;
          haveLast <= 1'b1;
        end else if (!haveLast) begin
          errPulse <= 1'b1;
        end else if (runCount != '0) begin
          outValid <= 1'b1;
          runLeft  <= runCount - 1'b1;
        end
      end
    end
  end

  // R5: an error pulse never comes with an output word
  a_r5_err_no_output: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid);
  // R5: the pulse lasts one cycle
  a_r5_err_single: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
endmodule

// File: rtl/bitmask_decoder.sv
module bitmask_decoder
  import bmd_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DICT_N = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [$clog2(DICT_N)-1:0] cfgIdx,
  input  logic [WORD_W-1:0]         cfgWord,
  input  logic                      inBit,
  input  logic                      inValid,
  output logic                      inReady,
  output logic [WORD_W-1:0]         outWord,
  output logic                      outValid,
  input  logic                      outReady,
  output logic                      errPulse
);
  localparam int RUN_W = $clog2(WORD_W/2) + $clog2(DICT_N);

  ctlStrobes_t      ctl;
  logic             codeDone, isRepeat;
  logic [RUN_W-1:0] runCount;

  bmd_datapath #(.WORD_W(WORD_W), .DICT_N(DICT_N)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inBit(inBit),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .codeDone(codeDone), .isRepeat(isRepeat), .runCount(runCount),
    .outWord(outWord)
  );

  bmd_control #(.RUN_W(RUN_W)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .codeDone(codeDone), .isRepeat(isRepeat), .runCount(runCount),
    .ctl(ctl), .inReady(inReady), .outValid(outValid), .errPulse(errPulse)
  );

  // R7: a stalled word holds its value and valid
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));
  // R7: no input beat while a word is pending
  a_r7_no_input_while_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && inValid) |=> $stable(outWord) || $past(ctl.loadWord));
endmodule

// File: tb/tb_bitmask_decoder.sv
`timescale 1ns/1ps
module tb_bitmask_decoder;
  logic       clk = 1'b0;
  logic       rstN, cfgWe, cfgIdx, inBit, inValid, outReady;
  logic [7:0] cfgWord, outWord;
  logic       inReady, outValid, errPulse;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  bitmask_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .inBit(inBit), .inValid(inValid), .inReady(inReady),
    .outWord(outWord), .outValid(outValid), .outReady(outReady),
    .errPulse(errPulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // send a code, first bit = bits[n-1]; returns at the negedge after the last bit
  task automatic sendCode(input logic [8:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      inValid = 1'b1;
      inBit   = bits[i];
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic writeDict(input logic idx, input logic [7:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgWord = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one word due one cycle after the last bit; consume it
  task automatic expectOne(input string req, input logic [7:0] exp);
    chk(!outValid, "R6", {req, " not yet valid"}, outValid, 0);
    @(negedge clk);
    chk(outValid, "R6", {req, " valid after one cycle"}, outValid, 1);
    chk(outWord == exp, req, "word", outWord, exp);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, req, "idle after consume", outValid, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; cfgWe = 0; cfgIdx = 0; cfgWord = 0;
    inBit = 0; inValid = 0; outReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid, "R8", "outValid", outValid, 0);
    chk(inReady,   "R8", "inReady", inReady, 1);
    chk(!errPulse, "R8", "errPulse", errPulse, 0);
  endtask

  task automatic testEarlyRepeat();
    sendCode({2'b00, 2'b01, 2'b00, 1'b1}, 7);  // R5 repeat, no prior word
    chk(!errPulse, "R5", "pulse not yet", errPulse, 0);
    @(negedge clk);
    chk(errPulse,  "R5", "pulse", errPulse, 1);
    chk(!outValid, "R5", "no output", outValid, 0);
    @(negedge clk);
    chk(!errPulse, "R5", "pulse one cycle", errPulse, 0);
    chk(!outValid, "R5", "still no output", outValid, 0);
  endtask

  task automatic testRaw();
    sendCode({1'b1, 8'h96}, 9);
    expectOne("R1", 8'h96);
  endtask

  task automatic testDirect();
    sendCode({2'b01, 1'b0}, 3);
    expectOne("R2", 8'hA5);
    sendCode({2'b01, 1'b1}, 3);
    expectOne("R2", 8'h3C);
  endtask

  task automatic testMask();
    sendCode({2'b00, 2'b00, 2'b11, 1'b0}, 7);  // A5 ^ C0
    expectOne("R3", 8'h65);
    sendCode({2'b00, 2'b11, 2'b01, 1'b1}, 7);  // 3C ^ 01
    expectOne("R3", 8'h3D);
    sendCode({2'b00, 2'b01, 2'b10, 1'b0}, 7);  // A5 ^ 20
    expectOne("R3", 8'h85);
  endtask

  task automatic testRun();
    int got = 0;
    sendCode({2'b00, 2'b10, 2'b00, 1'b1}, 7);  // R4 count 5 of 0x85
    @(negedge clk);
    outReady = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (outValid && outWord == 8'h85) got++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(got == 5, "R4", "run beats", got, 5);
    chk(!outValid, "R4", "run ends", outValid, 0);
    sendCode({2'b00, 2'b00, 2'b00, 1'b0}, 7);  // R4 count 0
    got = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (outValid) got++;
    end
    chk(got == 0, "R4", "count zero emits nothing", got, 0);
    chk(inReady, "R4", "ready after count zero", inReady, 1);
  endtask

  task automatic testStall();
    int bad = 0;
    sendCode({1'b1, 8'h5A}, 9);
    @(negedge clk);
    inValid = 1'b1; inBit = 1'b1;              // R7 offered bits must be ignored
    for (int k = 0; k < 5; k++) begin
      if (!outValid || outWord != 8'h5A || inReady) bad++;
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(bad == 0, "R7", "hold during stall", bad, 0);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, "R7", "one beat only", outValid, 0);
    sendCode({2'b01, 1'b0}, 3);
    expectOne("R7", 8'hA5);
    // stall in the middle of a repeat run of 2
    sendCode({2'b00, 2'b01, 2'b00, 1'b0}, 7);  // count {01,0}=2 of 0xA5
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      if (!outValid || outWord != 8'hA5) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7", "run held on stall", bad, 0);
    outReady = 1'b1;
    bad = 0;
    for (int k = 0; k < 2; k++) begin
      if (!outValid) bad++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(bad == 0 && !outValid, "R7", "run exact after stall", bad, 0);
  endtask

  task automatic testRewrite();
    writeDict(1'b1, 8'hF0);
    sendCode({2'b01, 1'b1}, 3);
    expectOne("R9", 8'hF0);
  endtask

  initial begin
    testReset();
    writeDict(1'b0, 8'hA5);
    writeDict(1'b1, 8'h3C);
    testEarlyRepeat();
    testRaw();
    testDirect();
    testMask();
    testRun();
    testStall();
    testRewrite();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (R6): actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule